// File: doc/BRIEF.md
# Two-Stage Converter Code Register

This block is the digital front end of a 10-bit converter. A host loads a code into a first-stage input register. The code then moves into a second-stage output register, and that register drives the converter code pins. The host can be a processor with an 8-bit bus, which needs two byte writes per code, or a processor with a 16-bit bus, which needs one write. The block can also run stand-alone, with no processor attached.

Configuration pins choose how a code reaches the output register. It can move automatically when a byte pair completes, on a processor transfer strobe, on an external transfer signal, straight through on the write, or fully transparently from the data pins. The processor strobe can be wired to several instances so that their outputs change on the same clock edge. Byte packing can be left- or right-justified, and either byte of a pair can come first.

Top module: `dac_dbuf`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) clears the input register, the output register and the pending-byte state to zero, so `code_out` reads 0 after reset in every mode except transparent.
- R2: With `bus_mode`=0 (byte bus), each write carries one byte on `data_in[7:0]`, and `byte_hi`=1 marks the upper byte. When `msb_first`=1 the upper byte is written first, and when it is 0 the lower byte is written first. The first byte is held pending. The second byte completes the code into the input register.
- R3: For byte packing with `left_just`=1, code[9:2] is the upper byte and code[1:0] is lower-byte bits 7:6. With `left_just`=0, code[7:0] is the lower byte and code[9:8] is upper-byte bits 1:0. For a word write, `left_just`=1 takes `data_in[15:6]` and 0 takes `data_in[9:0]`. All other data bits are ignored.
- R4: Byte bus with `sub_mode`=0 (automatic): the output register takes the new code on the edge that writes the second byte. A lone first byte leaves `code_out` unchanged.
- R5: Byte bus with `sub_mode`=1 or 3 (strobe): a clock edge with `xfer`=1 copies the input register to the output register, and `ext_xfer` has no effect. A strobe that arrives while only the first byte of a new pair is written delivers the previous complete code.
- R6: Byte bus with `sub_mode`=2 (external): `ext_xfer`=1 copies the input register to the output register, and `xfer` has no effect.
- R7: With `bus_mode`=1 or 3 (word bus), `sub_mode`=0 means a write loads both registers on the same edge. Any other `sub_mode` loads only the input register, and the output register then waits for `xfer`.
- R8: With `bus_mode`=2 (stand-alone), `wr`=1 writes a word regardless of `sel`. `sub_mode`=0 loads both registers on the write, 2 selects transparent mode, and 1 or 3 uses both registers with `xfer`.
- R9: In transparent mode, `code_out` follows the decoded `data_in` within the same cycle, without waiting for a clock edge.
- R10: In byte and word bus modes, a write needs `sel`=1 and `wr`=1 on the same edge. A write with `sel`=0 changes nothing.
- R11: Outside transparent mode, the output register changes only on a write that its mode loads directly, or on the transfer signal that its mode accepts.
- R12: Several instances that share one `xfer` line, each in a strobe mode, all present their new codes on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_mode | input | 2 | 0 byte bus, 1 or 3 word bus, 2 stand-alone |
| sub_mode | input | 2 | Transfer policy within the bus mode |
| left_just | input | 1 | 1 left-justified, 0 right-justified packing |
| msb_first | input | 1 | 1 upper byte first on the byte bus |
| sel | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high |
| byte_hi | input | 1 | Byte bus: 1 when this write carries the upper byte |
| data_in | input | 16 | Write data |
| xfer | input | 1 | Processor transfer strobe, shareable |
| ext_xfer | input | 1 | External transfer signal |
| code_out | output | 10 | Code to the converter |

## Verification
The hardest case to reach from the ports is a strobe that lands between the two bytes of a pair. To get there, the stimulus first loads one complete code without transferring it. It then writes only the first byte of a different code and pulses the strobe. The output must show the earlier complete code, and must show the new code only after the second byte and a later strobe. Full sweeps of all 1024 codes run across every justification and byte-order combination, across word packing and across transparent mode. A second instance on the shared strobe shows that both outputs change on the same edge.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    typedef enum logic [1:0] {
        BUS_BYTE  = 2'd0,
        BUS_WORD  = 2'd1,
        BUS_SOLO  = 2'd2,
        BUS_WORD2 = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        POL_AUTO   = 3'd0,
        POL_STROBE = 3'd1,
        POL_EXT    = 3'd2,
        POL_DIRECT = 3'd3,
        POL_FLOW   = 3'd4
    } xfer_pol_e;

endpackage

// File: rtl/dac_dbuf_policy.sv
module dac_dbuf_policy
    import dac_dbuf_pkg::*;
(
    input  logic [1:0] bus_mode,
    input  logic [1:0] sub_mode,
    output xfer_pol_e  pol,
    output logic       is_byte,
    output logic       solo
);

    always_comb begin
        pol     = POL_STROBE;
        is_byte = 1'b0;
        solo    = 1'b0;
        unique case (bus_kind_e'(bus_mode))
            BUS_BYTE: begin
                is_byte = 1'b1;
                case (sub_mode)
                    2'd0:    pol = POL_AUTO;
                    2'd2:    pol = POL_EXT;
                    default: pol = POL_STROBE;
                endcase
            end
            BUS_SOLO: begin
                solo = 1'b1;
                case (sub_mode)
                    2'd0:    pol = POL_DIRECT;
                    2'd2:    pol = POL_FLOW;
                    default: pol = POL_STROBE;
                endcase
            end
            default: begin
                pol = (sub_mode == 2'd0) ? POL_DIRECT : POL_STROBE;
            end
        endcase
    end

endmodule

// File: rtl/dac_dbuf_unpack.sv
module dac_dbuf_unpack #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] data_in,
    input  logic                left_just,
    input  logic                byte_hi,
    input  logic [BYTE_W-1:0]   part_byte,
    output logic [CODE_W-1:0]   word_code,
    output logic [CODE_W-1:0]   pair_code
);

    localparam int unsigned WORD_W  = 2 * BYTE_W;
    localparam int unsigned SPILL_W = CODE_W - BYTE_W;

    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;
    logic [CODE_W-1:0] left_word;
    logic [CODE_W-1:0] right_word;
    logic [CODE_W-1:0] left_pair;
    logic [CODE_W-1:0] right_pair;

    assign cur_byte = data_in[BYTE_W-1:0];
    assign hi_byte  = byte_hi ? cur_byte : part_byte;
    assign lo_byte  = byte_hi ? part_byte : cur_byte;

    generate
        if (CODE_W == WORD_W) begin : g_full
            assign left_word  = data_in;
            assign right_word = data_in;
        end else begin : g_part
            assign left_word  = data_in[WORD_W-1 -: CODE_W];
            assign right_word = data_in[CODE_W-1:0];
        end
    endgenerate

    assign left_pair  = {hi_byte, lo_byte[BYTE_W-1 -: SPILL_W]};
    assign right_pair = {hi_byte[SPILL_W-1:0], lo_byte};

    assign word_code = left_just ? left_word : right_word;
    assign pair_code = left_just ? left_pair : right_pair;

endmodule

// File: rtl/dac_dbuf_pair_trk.sv
module dac_dbuf_pair_trk #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ev,
    input  logic              is_byte,
    input  logic              byte_hi,
    input  logic              msb_first,
    input  logic [BYTE_W-1:0] cur_byte,
    output logic [BYTE_W-1:0] part_byte,
    output logic              pend,
    output logic              done_wr
);

    typedef struct packed {
        logic [BYTE_W-1:0] part;
        logic              pend;
    } trk_t;

    trk_t trk_d, trk_q;
    logic opens_pair;
    logic byte_wr;

    assign byte_wr    = wr_ev & is_byte;
    assign opens_pair = byte_wr & (byte_hi == msb_first);
    assign done_wr    = byte_wr & (byte_hi != msb_first);

    always_comb begin
        trk_d = trk_q;
        if (opens_pair) begin
            trk_d.part = cur_byte;
            trk_d.pend = 1'b1;
        end else if (done_wr) begin
            trk_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign part_byte = trk_q.part;
    assign pend      = trk_q.pend;

endmodule

// File: rtl/dac_dbuf.sv
module dac_dbuf
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            bus_mode,
    input  logic [1:0]            sub_mode,
    input  logic                  left_just,
    input  logic                  msb_first,
    input  logic                  sel,
    input  logic                  wr,
    input  logic                  byte_hi,
    input  logic [2*BYTE_W-1:0]   data_in,
    input  logic                  xfer,
    input  logic                  ext_xfer,
    output logic [CODE_W-1:0]     code_out
);

    typedef struct packed {
        logic [CODE_W-1:0] in_code;
        logic [CODE_W-1:0] out_code;
    } stage_t;

    stage_t st_d, st_q;

    xfer_pol_e         pol;
    logic              is_byte;
    logic              solo;
    logic              wr_ev;
    logic              done_wr;
    logic              pend_q;
    logic [BYTE_W-1:0] part_byte;
    logic [CODE_W-1:0] word_code;
    logic [CODE_W-1:0] pair_code;
    logic [CODE_W-1:0] in_code_q;
    logic [CODE_W-1:0] out_code_q;

    dac_dbuf_policy policy_i (
        .bus_mode (bus_mode),
        .sub_mode (sub_mode),
        .pol      (pol),
        .is_byte  (is_byte),
        .solo     (solo)
    );

    // stand-alone ignores chip select
    assign wr_ev = wr & (sel | solo);

    dac_dbuf_pair_trk #(.BYTE_W(BYTE_W)) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (wr_ev),
        .is_byte   (is_byte),
        .byte_hi   (byte_hi),
        .msb_first (msb_first),
        .cur_byte  (data_in[BYTE_W-1:0]),
        .part_byte (part_byte),
        .pend      (pend_q),
        .done_wr   (done_wr)
    );

    dac_dbuf_unpack #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) unpack_i (
        .data_in   (data_in),
        .left_just (left_just),
        .byte_hi   (byte_hi),
        .part_byte (part_byte),
        .word_code (word_code),
        .pair_code (pair_code)
    );

    always_comb begin
        st_d = st_q;
        if (is_byte) begin
            if (done_wr) begin
                st_d.in_code = pair_code;
            end
            unique case (pol)
                POL_AUTO:   if (done_wr)  st_d.out_code = pair_code;
                POL_EXT:    if (ext_xfer) st_d.out_code = st_q.in_code;
                default:    if (xfer)     st_d.out_code = st_q.in_code;
            endcase
        end else begin
            unique case (pol)
                POL_FLOW: begin
                    st_d.in_code  = word_code;
                    st_d.out_code = word_code;
                end
                POL_DIRECT: begin
                    if (wr_ev) begin
                        st_d.in_code  = word_code;
                        st_d.out_code = word_code;
                    end
                end
                default: begin
                    if (wr_ev) st_d.in_code  = word_code;
                    if (xfer)  st_d.out_code = st_q.in_code;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_code_q  = st_q.in_code;
    assign out_code_q = st_q.out_code;
    assign code_out   = (pol == POL_FLOW) ? word_code : st_q.out_code;

endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input xfer_pol_e         pol,
    input logic              is_byte,
    input logic              solo,
    input logic              sel,
    input logic              wr,
    input logic              byte_hi,
    input logic              msb_first,
    input logic              xfer,
    input logic              ext_xfer,
    input logic              pend_q,
    input logic [CODE_W-1:0] in_code_q,
    input logic [CODE_W-1:0] out_code_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_code_q == '0 && out_code_q == '0 && !pend_q));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol != POL_FLOW && !xfer && !ext_xfer && !wr) |=> $stable(out_code_q));

    // R5
    strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_STROBE && xfer) |=> (out_code_q == $past(in_code_q)));

    // R5
    strobe_ignores_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_STROBE && !xfer) |=> $stable(out_code_q));

    // R6
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_EXT && ext_xfer) |=> (out_code_q == $past(in_code_q)));

    // R6
    ext_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_EXT && !ext_xfer) |=> $stable(out_code_q));

    // R2
    first_byte_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_byte && sel && wr && (byte_hi == msb_first)) |=> pend_q);

    // R10
    desel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!solo && !sel) |=> $stable(in_code_q));

endmodule

bind dac_dbuf dac_dbuf_chk #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pol        (pol),
    .is_byte    (is_byte),
    .solo       (solo),
    .sel        (sel),
    .wr         (wr),
    .byte_hi    (byte_hi),
    .msb_first  (msb_first),
    .xfer       (xfer),
    .ext_xfer   (ext_xfer),
    .pend_q     (pend_q),
    .in_code_q  (in_code_q),
    .out_code_q (out_code_q)
);

// File: tb/dac_dbuf_tb_top.sv
module dac_dbuf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'd0;
    logic [1:0]  sub_mode = 2'd0;
    logic        left_just = 1'b0;
    logic        msb_first = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic        byte_hi = 1'b0;
    logic [15:0] data_in = 16'h0;
    logic        xfer = 1'b0;
    logic        ext_xfer = 1'b0;
    logic [9:0]  code_out;

    logic        sel_b = 1'b0;
    logic        wr_b = 1'b0;
    logic [15:0] data_b = 16'h0;
    logic [9:0]  code_out_b;

    int total = 0;
    int bad = 0;
    int exp_out = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dac_dbuf dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .sub_mode(sub_mode),
        .left_just(left_just), .msb_first(msb_first), .sel(sel), .wr(wr),
        .byte_hi(byte_hi), .data_in(data_in), .xfer(xfer), .ext_xfer(ext_xfer),
        .code_out(code_out)
    );

    // second instance on the shared strobe: word bus, double buffered, right-justified
    dac_dbuf dut_b_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(2'd1), .sub_mode(2'd1),
        .left_just(1'b0), .msb_first(1'b0), .sel(sel_b), .wr(wr_b),
        .byte_hi(1'b0), .data_in(data_b), .xfer(xfer), .ext_xfer(1'b0),
        .code_out(code_out_b)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hi_of(input int code, input bit lj);
        if (lj) return 8'(code >> 2);
        return 8'(8'hD4 | (code >> 8));
    endfunction

    function automatic logic [7:0] lo_of(input int code, input bit lj);
        if (lj) return 8'(((code & 3) << 6) | 26);
        return 8'(code & 255);
    endfunction

    function automatic logic [15:0] word_of(input int code, input bit lj);
        if (lj) return 16'((code << 6) | 43);
        return 16'((45 << 10) | code);
    endfunction

    task automatic byte_wr(input bit hi, input logic [7:0] b, input bit s);
        @(negedge clk);
        sel = s; wr = 1'b1; byte_hi = hi; data_in = {8'hA5, b};
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic put_first(input int code);
        if (msb_first) byte_wr(1'b1, hi_of(code, left_just), 1'b1);
        else           byte_wr(1'b0, lo_of(code, left_just), 1'b1);
    endtask

    task automatic put_second(input int code);
        if (msb_first) byte_wr(1'b0, lo_of(code, left_just), 1'b1);
        else           byte_wr(1'b1, hi_of(code, left_just), 1'b1);
    endtask

    task automatic word_wr(input int code, input bit s);
        @(negedge clk);
        sel = s; wr = 1'b1; data_in = word_of(code, left_just);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic pulse_x();
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
    endtask

    task automatic pulse_e();
        @(negedge clk); ext_xfer = 1'b1;
        @(negedge clk); ext_xfer = 1'b0;
    endtask

    task automatic set_cfg(input int bm, input int sm, input bit lj, input bit mf);
        @(negedge clk);
        bus_mode = 2'(bm); sub_mode = 2'(sm); left_just = lj; msb_first = mf;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output", int'(code_out), 0);
        check("R1 reset second instance", int'(code_out_b), 0);

        // R2 R3 R4: automatic byte transfer, every code, every packing and order
        exp_out = 0;
        for (int lj = 0; lj < 2; lj++) begin
            for (int mf = 0; mf < 2; mf++) begin
                set_cfg(0, 0, 1'(lj), 1'(mf));
                for (int c = 0; c < 1024; c++) begin
                    put_first(c);
                    check("R4 first byte holds", int'(code_out), exp_out);
                    put_second(c);
                    check("R2 R3 pair assembled", int'(code_out), c);
                    exp_out = c;
                end
            end
        end

        // R5: processor strobe, including a half-written pair
        set_cfg(0, 1, 1'b1, 1'b1);
        put_first(677); put_second(677);
        check("R5 no output before strobe", int'(code_out), exp_out);
        pulse_e();
        check("R5 external ignored", int'(code_out), exp_out);
        pulse_x();
        check("R5 strobe loads", int'(code_out), 677);
        put_first(346); put_second(346);
        put_first(1023);
        pulse_x();
        check("R5 previous complete code", int'(code_out), 346);
        put_second(1023);
        check("R11 hold until strobe", int'(code_out), 346);
        pulse_x();
        check("R5 completed code", int'(code_out), 1023);
        set_cfg(0, 3, 1'b0, 1'b0);
        put_first(85);
        pulse_x();
        check("R5 mode 3 half pair", int'(code_out), 1023);
        put_second(85);
        pulse_x();
        check("R5 mode 3 strobe", int'(code_out), 85);

        // R6: external transfer
        set_cfg(0, 2, 1'b0, 1'b1);
        put_first(512); put_second(512);
        pulse_x();
        check("R6 strobe ignored", int'(code_out), 85);
        pulse_e();
        check("R6 external loads", int'(code_out), 512);

        // R7 R3: word bus single buffered, every code, both packings
        for (int lj = 0; lj < 2; lj++) begin
            set_cfg(1, 0, 1'(lj), 1'b0);
            for (int c = 0; c < 1024; c++) begin
                word_wr(1023 - c, 1'b1);
                check("R7 R3 word single", int'(code_out), 1023 - c);
            end
        end
        exp_out = 0;

        // R7: word bus double buffered (mode 3 alias)
        set_cfg(3, 2, 1'b1, 1'b0);
        word_wr(700, 1'b1);
        check("R7 double waits", int'(code_out), 0);
        pulse_x();
        check("R7 double strobe", int'(code_out), 700);

        // R10: deselected writes
        set_cfg(1, 0, 1'b0, 1'b0);
        word_wr(33, 1'b0);
        check("R10 word deselected", int'(code_out), 700);
        set_cfg(0, 0, 1'b1, 1'b1);
        byte_wr(1'b1, hi_of(44, 1'b1), 1'b0);
        byte_wr(1'b0, lo_of(44, 1'b1), 1'b0);
        check("R10 byte deselected", int'(code_out), 700);

        // R8: stand-alone
        set_cfg(2, 0, 1'b1, 1'b0);
        word_wr(123, 1'b0);
        check("R8 solo ignores select", int'(code_out), 123);
        set_cfg(2, 1, 1'b0, 1'b0);
        word_wr(456, 1'b0);
        check("R8 solo double waits", int'(code_out), 123);
        pulse_x();
        check("R8 solo double strobe", int'(code_out), 456);

        // R9: transparent, every code, both packings
        for (int lj = 0; lj < 2; lj++) begin
            set_cfg(2, 2, 1'(lj), 1'b0);
            for (int c = 0; c < 1024; c++) begin
                @(negedge clk);
                data_in = word_of(c, 1'(lj));
                #2;
                check("R9 flow through", int'(code_out), c);
            end
        end
        set_cfg(2, 1, 1'b1, 1'b0);
        check("R11 leaves flow holding", int'(code_out), 1023);

        // R12: shared strobe across two instances
        set_cfg(1, 1, 1'b1, 1'b0);
        word_wr(300, 1'b1);
        @(negedge clk);
        sel_b = 1'b1; wr_b = 1'b1; data_b = 16'(800);
        @(negedge clk);
        sel_b = 1'b0; wr_b = 1'b0;
        check("R12 first waits", int'(code_out), 1023);
        check("R12 second waits", int'(code_out_b), 0);
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
        check("R12 first updated", int'(code_out), 300);
        check("R12 second same edge", int'(code_out_b), 800);

        // R1: reset mid-run
        set_cfg(0, 1, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", int'(code_out), 0);
        rst_n = 1'b1;
        pulse_x();
        check("R1 input stage cleared", int'(code_out), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule